// File: doc/BRIEF.md
# Condition Code Flag Register

This block keeps the four status flags that a processor's conditional branches test: negative (N), zero (Z), overflow (V) and carry (C). When the execution unit finishes an operation it offers its result, its carry-out and its signed-overflow indication, and tags the operation as arithmetic, logic or neither. On an enabled clock edge the block records the flags that this operation defines. A logic operation touches only N and Z. An arithmetic operation rewrites all four.

Beside the flag storage sits a branch-condition evaluator. A condition code, driven by the branch logic, is compared against the stored flags, and the block reports whether the branch would be taken. The evaluator reads only the registered flags, so a branch always sees the flags left by the last completed update.

Top module: `ccr_flags_top`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, all four flags become 0 after that edge, whatever the other inputs are.
- R2: On an update edge (`upd_en` high, `op_class` arithmetic 2'b10 or logic 2'b01), N takes bit 31 of `alu_result`.
- R3: On an update edge, Z becomes 1 if `alu_result` is all zeros and 0 otherwise.
- R4: On an update edge with `op_class` = 2'b10 (arithmetic), V takes `alu_ovf` and C takes `alu_carry`.
- R5: On an update edge with `op_class` = 2'b01 (logic), V and C keep their previous values.
- R6: When `upd_en` is low, or `op_class` is 2'b00 (none) or 2'b11 (reserved), all four flags hold.
- R7: The flag outputs are registered. A qualifying stimulus changes them at the next rising edge and at no earlier time.
- R8: `cond_true` is combinational from `cond_sel` and the stored flags. The codes are 0 always (1), 1 equal (Z), 2 not equal (!Z), 3 negative (N), 4 greater than zero (!N & !Z), 5 carry set (C), 6 overflow set (V), 7 never (0), 8 non-negative (!N), 9 carry clear (!C), 10 overflow clear (!V) and 11 less or equal to zero (N | Z).
- R9: Codes 12 to 15 are unassigned and always give `cond_true` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_en | input | 1 | Allows a flag update on this edge |
| op_class | input | 2 | 00 none, 01 logic, 10 arithmetic, 11 reserved (treated as none) |
| alu_result | input | 32 | Result of the current operation |
| alu_carry | input | 1 | Carry-out of the current operation |
| alu_ovf | input | 1 | Signed overflow of the current operation |
| cond_sel | input | 4 | Branch condition code to evaluate |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_c | output | 1 | Stored carry flag |
| cond_true | output | 1 | Requested condition holds on the stored flags |

## Verification
Each flag update is due exactly one rising edge after its inputs are presented. The driver applies each stimulus on a falling edge and queues the flags it expects. The monitor pops and compares those flags shortly after the next rising edge, so every sample falls between the register update and the next stimulus. `cond_true` is due in the same cycle as `cond_sel`. It is sampled 1 ns after a code is driven, with update disabled so that the stored flags stay fixed during the sweep of all sixteen codes.

// File: rtl/ccr_pkg.sv
// Package: shared encodings for the condition code flag register.
// Assumes: a 2-bit operation class and a 4-bit condition code.
package ccr_pkg;

    localparam int OPC_W  = 2;
    localparam int COND_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_NONE  = 2'b00,
        OPC_LOGIC = 2'b01,
        OPC_ARITH = 2'b10,
        OPC_RSVD  = 2'b11
    } opc_e;

    typedef enum logic [COND_W-1:0] {
        CND_ALWAYS = 4'd0,
        CND_EQ     = 4'd1,
        CND_NE     = 4'd2,
        CND_NEG    = 4'd3,
        CND_GTZ    = 4'd4,
        CND_CS     = 4'd5,
        CND_VS     = 4'd6,
        CND_NEVER  = 4'd7,
        CND_PL     = 4'd8,
        CND_CC     = 4'd9,
        CND_VC     = 4'd10,
        CND_LEZ    = 4'd11
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/ccr_flag_next.sv
// Module: ccr_flag_next
// Computes the next flag value and the load strobe from the operation
// that the execution unit presents.
// Assumes: the result is two's complement, so its top bit is the sign.
module ccr_flag_next
    import ccr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              upd_en,
    input  logic [OPC_W-1:0]  op_class,
    input  logic [DATA_W-1:0] result,
    input  logic              carry,
    input  logic              ovf,
    input  flags_t            cur,
    output flags_t            nxt,
    output logic              load
);

    localparam int SIGN_BIT = DATA_W - 1;

    opc_e cls;
    logic is_arith;
    logic is_logic;

    assign cls      = opc_e'(op_class);
    assign is_arith = (cls == OPC_ARITH);
    assign is_logic = (cls == OPC_LOGIC);

    // Purpose: load only for a real operation class while enabled.
    always_comb begin
        load = upd_en && (is_arith || is_logic);
    end

    // Purpose: form new flags; V and C follow only arithmetic operations.
    always_comb begin
        nxt.n = result[SIGN_BIT];
        nxt.z = (result == '0);
        nxt.v = is_arith ? ovf   : cur.v;
        nxt.c = is_arith ? carry : cur.c;
    end

endmodule

// File: rtl/ccr_flag_store.sv
// Module: ccr_flag_store
// Holds the four flags; loads on strobe, clears on synchronous reset.
// Assumes: rst_n is active low and sampled on the rising edge.
module ccr_flag_store
    import ccr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  flags_t nxt,
    output flags_t q
);

    // Purpose: flag register with synchronous clear and load enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= nxt;
        end
    end

    // R1: a reset edge leaves all flags cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R7: without a load the stored value stays put
    p_hold_without_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/ccr_cond_eval.sv
// Module: ccr_cond_eval
// Evaluates a branch condition code against the stored flags.
// Assumes: codes above the last assigned one are never taken.
module ccr_cond_eval
    import ccr_pkg::*;
(
    input  logic [COND_W-1:0] cond_sel,
    input  flags_t            flags,
    output logic              taken
);

    cond_e sel;
    assign sel = cond_e'(cond_sel);

    // Purpose: map the selected condition onto the flags.
    always_comb begin
        case (sel)
            CND_ALWAYS: taken = 1'b1;
            CND_EQ:     taken = flags.z;
            CND_NE:     taken = !flags.z;
            CND_NEG:    taken = flags.n;
            CND_GTZ:    taken = !flags.n && !flags.z;
            CND_CS:     taken = flags.c;
            CND_VS:     taken = flags.v;
            CND_NEVER:  taken = 1'b0;
            CND_PL:     taken = !flags.n;
            CND_CC:     taken = !flags.c;
            CND_VC:     taken = !flags.v;
            CND_LEZ:    taken = flags.n || flags.z;
            default:    taken = 1'b0;
        endcase
    end

    // Purpose: guard the fixed and complementary codes.
    always_comb begin
        if (sel == CND_ALWAYS) begin
            a_always_r8: assert (taken);
        end
        if (cond_sel > COND_W'(CND_LEZ)) begin
            a_unassigned_r9: assert (!taken);
        end
    end

endmodule

// File: rtl/ccr_flags_top.sv
// Module: ccr_flags_top
// Condition code flag register with branch-condition evaluator.
// Assumes: the execution unit supplies carry and overflow; the flags it
// records become visible one rising edge after the operation.
module ccr_flags_top
    import ccr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        op_class,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    input  logic [3:0]        cond_sel,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              cond_true
);

    flags_t cur_flags;
    flags_t nxt_flags;
    logic   do_load;

    ccr_flag_next #(.DATA_W(DATA_W)) u_next (
        .upd_en   (upd_en),
        .op_class (op_class),
        .result   (alu_result),
        .carry    (alu_carry),
        .ovf      (alu_ovf),
        .cur      (cur_flags),
        .nxt      (nxt_flags),
        .load     (do_load)
    );

    ccr_flag_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (do_load),
        .nxt   (nxt_flags),
        .q     (cur_flags)
    );

    ccr_cond_eval u_eval (
        .cond_sel (cond_sel),
        .flags    (cur_flags),
        .taken    (cond_true)
    );

    assign flag_n = cur_flags.n;
    assign flag_z = cur_flags.z;
    assign flag_v = cur_flags.v;
    assign flag_c = cur_flags.c;

    // R2: sign of an accepted result lands in N
    p_sign_to_n_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (op_class == 2'b01 || op_class == 2'b10))
        |=> (flag_n == $past(alu_result[DATA_W-1])));

    // R3: an all-zero accepted result sets Z
    p_zero_to_z_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (op_class == 2'b01 || op_class == 2'b10))
        |=> (flag_z == ($past(alu_result) == '0)));

    // R4: arithmetic copies overflow and carry
    p_arith_vc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_class == 2'b10)
        |=> (flag_v == $past(alu_ovf) && flag_c == $past(alu_carry)));

    // R5: logic leaves V and C alone
    p_logic_keeps_vc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_class == 2'b01) |=> ($stable(flag_v) && $stable(flag_c)));

    // R6: no enable or a non-operation class holds every flag
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en || op_class == 2'b00 || op_class == 2'b11)
        |=> ($stable(flag_n) && $stable(flag_z) && $stable(flag_v) && $stable(flag_c)));

endmodule

// File: tb/ccr_flags_top_bench.sv
// Scoreboard bench: the driver queues the expected flags, and the monitor
// pops and compares them one rising edge after each stimulus.
module ccr_flags_top_bench;

    localparam int  W    = 32;
    localparam time HALF = 4ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         upd_en = 1'b1;
    logic [1:0]   op_class = 2'b10;
    logic [W-1:0] alu_result = 32'h8000_0000;
    logic         alu_carry = 1'b1;
    logic         alu_ovf = 1'b1;
    logic [3:0]   cond_sel = 4'd0;
    logic         flag_n, flag_z, flag_v, flag_c, cond_true;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] m_flags = 4'b0000;   // bench model {n,z,v,c}
    logic [3:0] q_exp[$];
    string      q_tag[$];

    always #HALF clk = ~clk;

    ccr_flags_top u_ccr_flags_top (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
        .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
        .cond_sel(cond_sel), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .cond_true(cond_true)
    );

    // Monitor: each queued expectation is due one edge after its stimulus.
    always @(posedge clk) begin
        #2;
        if (q_exp.size() > 0) begin
            logic [3:0] exp_f;
            string      tag;
            exp_f = q_exp.pop_front();
            tag   = q_tag.pop_front();
            checks++;
            if ({flag_n, flag_z, flag_v, flag_c} !== exp_f) begin
                errors++;
                $display("FAIL %s flags nzvc actual %b expected %b", tag,
                         {flag_n, flag_z, flag_v, flag_c}, exp_f);
            end
        end
    end

    task automatic push(input string tag);
        q_exp.push_back(m_flags);
        q_tag.push_back(tag);
    endtask

    // Driver: present one operation and record what it should leave behind.
    task automatic step(input logic en, input logic [1:0] cls, input logic [W-1:0] res,
                        input logic cy, input logic ov, input string tag);
        @(negedge clk);
        rst_n = 1'b1; upd_en = en; op_class = cls;
        alu_result = res; alu_carry = cy; alu_ovf = ov;
        if (en && cls == 2'b10) m_flags = {res[W-1], res == 0, ov, cy};
        else if (en && cls == 2'b01) m_flags = {res[W-1], res == 0, m_flags[1:0]};
        push(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; upd_en = 1'b1; op_class = 2'b10;
        alu_result = 32'h8000_0000; alu_carry = 1'b1; alu_ovf = 1'b1;
        m_flags = 4'b0000;
        push(tag);
        @(negedge clk);
        rst_n = 1'b1; upd_en = 1'b0;
    endtask

    function automatic logic want_cond(input logic [3:0] s, input logic [3:0] f);
        logic n, z, v, c;
        {n, z, v, c} = f;
        case (s)
            4'd0: return 1'b1;
            4'd1: return z;
            4'd2: return !z;
            4'd3: return n;
            4'd4: return !n && !z;
            4'd5: return c;
            4'd6: return v;
            4'd7: return 1'b0;
            4'd8: return !n;
            4'd9: return !c;
            4'd10: return !v;
            4'd11: return n || z;
            default: return 1'b0;   // R9 unassigned codes
        endcase
    endfunction

    // R8 and R9: sweep every code against the stored flags in the same cycle.
    task automatic sweep_conds();
        @(negedge clk);
        upd_en = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 16; s++) begin
            cond_sel = 4'(s);
            #1;
            checks++;
            if (cond_true !== want_cond(4'(s), m_flags)) begin
                errors++;
                $display("FAIL %s code %0d flags %b actual %b expected %b",
                         (s > 11) ? "R9" : "R8", s, m_flags, cond_true,
                         want_cond(4'(s), m_flags));
            end
        end
    endtask

    initial begin
        do_reset("R1 reset at start");
        step(1'b1, 2'b10, 32'h0000_0000, 1'b0, 1'b0, "R3 arith zero");
        sweep_conds();
        step(1'b1, 2'b10, 32'h8000_0001, 1'b1, 1'b1, "R2 R4 arith negative carry ovf");
        sweep_conds();
        step(1'b1, 2'b01, 32'h0000_0000, 1'b0, 1'b0, "R5 logic zero keeps VC");
        step(1'b1, 2'b01, 32'h7FFF_FFFF, 1'b0, 1'b0, "R5 logic positive keeps VC");
        sweep_conds();
        step(1'b1, 2'b01, 32'hF000_0000, 1'b0, 1'b0, "R2 logic negative");
        step(1'b0, 2'b10, 32'h0000_0000, 1'b0, 1'b0, "R6 enable low holds");
        step(1'b1, 2'b00, 32'h0000_0000, 1'b0, 1'b0, "R6 class none holds");
        step(1'b1, 2'b11, 32'h0000_0000, 1'b0, 1'b0, "R6 class reserved holds");
        sweep_conds();
        step(1'b1, 2'b10, 32'h0000_0001, 1'b0, 1'b0, "R7 arith positive clears all");
        sweep_conds();
        step(1'b1, 2'b10, 32'h0000_0000, 1'b1, 1'b0, "R4 carry only");
        step(1'b1, 2'b10, 32'h4000_0000, 1'b0, 1'b1, "R4 ovf only");
        sweep_conds();
        do_reset("R1 reset after use");
        sweep_conds();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(2 * HALF * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule